// File: doc/BRIEF.md
# Capability Read Validation Gate

This block guards every read-side capability operation before a capability register may change. A request carries an operation code, a full capability (permission mask, base, limit, version, seal and a garbage-collection mark bit), an offset, the version the target object currently holds, and the destination register, thread and namespace slot. The gate accepts the request through a valid/ready handshake. It then walks a fixed sequence of one step per clock: permission, bounds, version match and seal recomputation.

When all four checks pass, the gate performs three steps in order, each a one-cycle pulse. It first tells the garbage collector that the slot is live, then writes the capability register, then updates the thread's shadow copy. The outgoing capability has its mark bit cleared. The first check that fails stops the operation. That check raises the single fault output with a code that names the failing stage, and nothing further happens for that request. A microcode-elevation input lets an operation skip only the permission test.

The namespace table, the collector, the register file, the shadow store and the fault handler sit outside. Only their strobes and data are produced here.

Top module: `cap_read_gate`

## Requirements
- R1: For a request that passes, accepted at clock edge k, gc_clr_o is high for exactly the cycle after edge k+4, creg_we_o after edge k+5, shadow_we_o after edge k+6 and done_o after edge k+7. gc_slot_o, creg_idx_o and shadow_tid_o carry the request's slot, register index and thread at those strobes.
- R2: Operation codes 0 to 5 require permission-mask bit 0 to 5 respectively (0 data read, 1 data write, 2 execute, 3 capability load, 4 capability save, 5 call). Codes 6 and 7 never pass. A permission failure raises fault_o after edge k+1 with fault_code_o = 1.
- R3: The bounds check passes only when base + offset, summed unsigned in ADDR_W+1 bits, has no carry out of ADDR_W bits and is at most limit. Otherwise fault_o rises after edge k+2 with code 2.
- R4: The version check passes only when the capability version equals the object version. Otherwise fault_o rises after edge k+3 with code 3.
- R5: The seal must equal a 32-bit FNV-1a hash. The hash starts from 0x811C9DC5 and, for each byte, XORs in the byte and then multiplies by 0x01000193 modulo 2^32. The bytes are, in order: the permission mask zero-extended to 8 bits, the base bytes least significant first, the limit bytes least significant first, and the version bytes least significant first. On a mismatch fault_o rises after edge k+4 with code 4.
- R6: fault_o is a one-cycle pulse, and its code names the earliest failing check in the order permission, bounds, version, seal. A faulted request produces no gc_clr_o, creg_we_o, shadow_we_o or done_o.
- R7: With req_elev_i high at acceptance, the permission check passes for any code and mask, including codes 6 and 7. The bounds, version and seal checks still apply.
- R8: cap_gmark_o shows the request's mark bit until the collector step, and reads 0 from creg_we_o onward. The other cap_* outputs carry the request's fields.
- R9: req_ready_o is high only while idle. Requests presented while busy are ignored. req_ready_o returns in the cycle after done_o or fault_o.
- R10: After reset, req_ready_o is 1 and all strobes, done_o, fault_o and fault_code_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Gate idle, request will be taken |
| req_op_i | input | 3 | Operation code |
| req_elev_i | input | 1 | Microcode elevation, skips the permission test |
| req_perm_i | input | 6 | Capability permission mask |
| req_base_i | input | ADDR_W | Capability base |
| req_limit_i | input | ADDR_W | Capability limit (inclusive) |
| req_ver_i | input | VER_W | Capability version |
| req_seal_i | input | 32 | Stored seal |
| req_gmark_i | input | 1 | Garbage-collection mark bit |
| req_off_i | input | OFF_W | Access offset |
| req_objver_i | input | VER_W | Current version of the target object |
| req_slot_i | input | SLOT_W | Namespace slot index |
| req_creg_i | input | CR_W | Destination capability register |
| req_tid_i | input | TID_W | Requesting thread |
| gc_clr_o | output | 1 | Mark-clear strobe to the collector |
| gc_slot_o | output | SLOT_W | Slot whose mark is cleared |
| creg_we_o | output | 1 | Capability register write strobe |
| creg_idx_o | output | CR_W | Register written |
| shadow_we_o | output | 1 | Thread shadow write strobe |
| shadow_tid_o | output | TID_W | Thread whose shadow is written |
| cap_perm_o | output | 6 | Outgoing permission mask |
| cap_base_o | output | ADDR_W | Outgoing base |
| cap_limit_o | output | ADDR_W | Outgoing limit |
| cap_ver_o | output | VER_W | Outgoing version |
| cap_seal_o | output | 32 | Outgoing seal |
| cap_gmark_o | output | 1 | Outgoing mark bit |
| done_o | output | 1 | Operation completed |
| fault_o | output | 1 | Operation rejected |
| fault_code_o | output | 3 | Failing stage code, valid with fault_o |

## Verification
Each outcome has a fixed cycle counted from the acceptance edge k. The four possible faults land after edges k+1 to k+4, the collector, register and shadow strobes after k+4, k+5 and k+6, done after k+7, and ready returns one edge after the end. The bench drives at falling edges and samples at falling edges. It logs the index of the edge after which each strobe first appears, and compares those indices with the exact values above. It also confirms that a strobe never occurs when it is not due. Busy-time requests are held high across the whole operation, and the bench checks that they change neither the timing nor the payload.

// File: rtl/cap_gate_pkg.sv
package cap_gate_pkg;

   localparam int NUM_OPS = 6;
   localparam int OP_W    = 3;
   localparam int PERM_W  = NUM_OPS;
   localparam int SEAL_W  = 32;
   localparam int FC_W    = 3;

   localparam logic [SEAL_W-1:0] FNV_BASIS = 32'h811C9DC5;
   localparam logic [SEAL_W-1:0] FNV_PRIME = 32'h01000193;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PERM,
      ST_BOUND,
      ST_VER,
      ST_SEAL,
      ST_GC,
      ST_CREG,
      ST_SHADOW,
      ST_DONE,
      ST_FAULT
   } gate_state_e;

   typedef enum logic [FC_W-1:0] {
      FC_NONE  = 3'd0,
      FC_PERM  = 3'd1,
      FC_BOUND = 3'd2,
      FC_VER   = 3'd3,
      FC_SEAL  = 3'd4
   } fault_code_e;

endpackage

// File: rtl/cap_perm_check.sv
module cap_perm_check #(
   parameter int NUM_OPS = 6,
   parameter int OP_W    = 3
) (
   input  logic [OP_W-1:0]    op_i,
   input  logic [NUM_OPS-1:0] perm_i,
   input  logic               elev_i,
   output logic               ok_o
);

   generate
      if ((2 ** OP_W) < NUM_OPS) begin : g_bad_width
         $error("cap_perm_check: OP_W too narrow for NUM_OPS");
      end
   endgenerate

   // one select line per defined operation; undefined codes select nothing
   logic [NUM_OPS-1:0] need;

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_need
         assign need[g] = (op_i == OP_W'(g));
      end
   endgenerate

   assign ok_o = elev_i | (|(need & perm_i));

endmodule

// File: rtl/cap_bounds_check.sv
module cap_bounds_check #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] limit_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic              ok_o
);

   generate
      if (OFF_W > ADDR_W) begin : g_bad_off
         $error("cap_bounds_check: OFF_W must not exceed ADDR_W");
      end
   endgenerate

   localparam int SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] sum;

   assign sum  = {1'b0, base_i} + SUM_W'(off_i);
   assign ok_o = !sum[ADDR_W] && (sum[ADDR_W-1:0] <= limit_i);

endmodule

// File: rtl/cap_seal_hash.sv
module cap_seal_hash
   import cap_gate_pkg::*;
#(
   parameter int NBYTES = 6
) (
   input  logic [NBYTES*8-1:0] msg_i,
   output logic [SEAL_W-1:0]   hash_o
);

   generate
      if (NBYTES < 1) begin : g_bad_len
         $error("cap_seal_hash: NBYTES must be at least 1");
      end
   endgenerate

   logic [SEAL_W-1:0] chain [NBYTES+1];

   assign chain[0] = FNV_BASIS;

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_round
         assign chain[g+1] = (chain[g] ^ {24'd0, msg_i[g*8 +: 8]}) * FNV_PRIME;
      end
   endgenerate

   assign hash_o = chain[NBYTES];

endmodule

// File: rtl/cap_read_gate.sv
module cap_read_gate
   import cap_gate_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 16,
   parameter int VER_W  = 8,
   parameter int SLOT_W = 8,
   parameter int CR_W   = 4,
   parameter int TID_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [OP_W-1:0]   req_op_i,
   input  logic              req_elev_i,
   input  logic [PERM_W-1:0] req_perm_i,
   input  logic [ADDR_W-1:0] req_base_i,
   input  logic [ADDR_W-1:0] req_limit_i,
   input  logic [VER_W-1:0]  req_ver_i,
   input  logic [SEAL_W-1:0] req_seal_i,
   input  logic              req_gmark_i,
   input  logic [OFF_W-1:0]  req_off_i,
   input  logic [VER_W-1:0]  req_objver_i,
   input  logic [SLOT_W-1:0] req_slot_i,
   input  logic [CR_W-1:0]   req_creg_i,
   input  logic [TID_W-1:0]  req_tid_i,
   output logic              gc_clr_o,
   output logic [SLOT_W-1:0] gc_slot_o,
   output logic              creg_we_o,
   output logic [CR_W-1:0]   creg_idx_o,
   output logic              shadow_we_o,
   output logic [TID_W-1:0]  shadow_tid_o,
   output logic [PERM_W-1:0] cap_perm_o,
   output logic [ADDR_W-1:0] cap_base_o,
   output logic [ADDR_W-1:0] cap_limit_o,
   output logic [VER_W-1:0]  cap_ver_o,
   output logic [SEAL_W-1:0] cap_seal_o,
   output logic              cap_gmark_o,
   output logic              done_o,
   output logic              fault_o,
   output logic [FC_W-1:0]   fault_code_o
);

   generate
      if ((ADDR_W % 8) != 0 || (VER_W % 8) != 0) begin : g_bad_align
         $error("cap_read_gate: ADDR_W and VER_W must be byte multiples");
      end
      if (PERM_W > 8) begin : g_bad_perm
         $error("cap_read_gate: permission mask must fit one byte");
      end
   endgenerate

   localparam int HASH_BYTES = 1 + 2 * (ADDR_W / 8) + (VER_W / 8);

   gate_state_e       state_q;
   fault_code_e       code_q;
   logic [OP_W-1:0]   op_q;
   logic              elev_q;
   logic [PERM_W-1:0] perm_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] limit_q;
   logic [VER_W-1:0]  ver_q;
   logic [SEAL_W-1:0] seal_q;
   logic              gmark_q;
   logic [OFF_W-1:0]  off_q;
   logic [VER_W-1:0]  objver_q;
   logic [SLOT_W-1:0] slot_q;
   logic [CR_W-1:0]   creg_q;
   logic [TID_W-1:0]  tid_q;

   logic                    perm_ok;
   logic                    bound_ok;
   logic                    ver_ok;
   logic                    seal_ok;
   logic [HASH_BYTES*8-1:0] hash_msg;
   logic [SEAL_W-1:0]       hash_val;

   cap_perm_check #(
      .NUM_OPS (NUM_OPS),
      .OP_W    (OP_W)
   ) perm_i (
      .op_i   (op_q),
      .perm_i (perm_q),
      .elev_i (elev_q),
      .ok_o   (perm_ok)
   );

   cap_bounds_check #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) bound_i (
      .base_i  (base_q),
      .limit_i (limit_q),
      .off_i   (off_q),
      .ok_o    (bound_ok)
   );

   // byte 0 is the mask, then base, limit and version, low byte first
   assign hash_msg = {ver_q, limit_q, base_q, 8'(perm_q)};

   cap_seal_hash #(
      .NBYTES (HASH_BYTES)
   ) hash_i (
      .msg_i  (hash_msg),
      .hash_o (hash_val)
   );

   assign ver_ok  = (ver_q == objver_q);
   assign seal_ok = (hash_val == seal_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         code_q   <= FC_NONE;
         op_q     <= '0;
         elev_q   <= 1'b0;
         perm_q   <= '0;
         base_q   <= '0;
         limit_q  <= '0;
         ver_q    <= '0;
         seal_q   <= '0;
         gmark_q  <= 1'b0;
         off_q    <= '0;
         objver_q <= '0;
         slot_q   <= '0;
         creg_q   <= '0;
         tid_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  op_q     <= req_op_i;
                  elev_q   <= req_elev_i;
                  perm_q   <= req_perm_i;
                  base_q   <= req_base_i;
                  limit_q  <= req_limit_i;
                  ver_q    <= req_ver_i;
                  seal_q   <= req_seal_i;
                  gmark_q  <= req_gmark_i;
                  off_q    <= req_off_i;
                  objver_q <= req_objver_i;
                  slot_q   <= req_slot_i;
                  creg_q   <= req_creg_i;
                  tid_q    <= req_tid_i;
                  state_q  <= ST_PERM;
               end
            end
            ST_PERM: begin
               if (perm_ok) begin
                  state_q <= ST_BOUND;
               end else begin
                  code_q  <= FC_PERM;
                  state_q <= ST_FAULT;
               end
            end
            ST_BOUND: begin
               if (bound_ok) begin
                  state_q <= ST_VER;
               end else begin
                  code_q  <= FC_BOUND;
                  state_q <= ST_FAULT;
               end
            end
            ST_VER: begin
               if (ver_ok) begin
                  state_q <= ST_SEAL;
               end else begin
                  code_q  <= FC_VER;
                  state_q <= ST_FAULT;
               end
            end
            ST_SEAL: begin
               if (seal_ok) begin
                  state_q <= ST_GC;
               end else begin
                  code_q  <= FC_SEAL;
                  state_q <= ST_FAULT;
               end
            end
            ST_GC: begin
               gmark_q <= 1'b0;
               state_q <= ST_CREG;
            end
            ST_CREG:   state_q <= ST_SHADOW;
            ST_SHADOW: state_q <= ST_DONE;
            ST_DONE:   state_q <= ST_IDLE;
            ST_FAULT: begin
               code_q  <= FC_NONE;
               state_q <= ST_IDLE;
            end
            default: begin
               code_q  <= FC_NONE;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign req_ready_o  = (state_q == ST_IDLE);
   assign gc_clr_o     = (state_q == ST_GC);
   assign creg_we_o    = (state_q == ST_CREG);
   assign shadow_we_o  = (state_q == ST_SHADOW);
   assign done_o       = (state_q == ST_DONE);
   assign fault_o      = (state_q == ST_FAULT);
   assign fault_code_o = fault_o ? code_q : FC_NONE;

   assign gc_slot_o    = slot_q;
   assign creg_idx_o   = creg_q;
   assign shadow_tid_o = tid_q;
   assign cap_perm_o   = perm_q;
   assign cap_base_o   = base_q;
   assign cap_limit_o  = limit_q;
   assign cap_ver_o    = ver_q;
   assign cap_seal_o   = seal_q;
   assign cap_gmark_o  = gmark_q;

endmodule

// File: rtl/cap_read_gate_chk.sv
module cap_read_gate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid_i,
   input logic       req_ready_o,
   input logic       gc_clr_o,
   input logic       creg_we_o,
   input logic       shadow_we_o,
   input logic       cap_gmark_o,
   input logic       done_o,
   input logic       fault_o,
   input logic [2:0] fault_code_o
);

   // R1
   creg_after_gc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      creg_we_o |-> $past(gc_clr_o));

   // R1
   shadow_after_creg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_we_o |-> $past(creg_we_o));

   // R1
   done_after_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(shadow_we_o));

   // R6
   single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gc_clr_o, creg_we_o, shadow_we_o, done_o, fault_o}));

   // R6
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> !fault_o);

   // R6
   fault_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (fault_code_o != 3'd0 && fault_code_o <= 3'd4));

   // R8
   gmark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      creg_we_o |-> !cap_gmark_o);

   // R9
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o) |=> !req_ready_o);

   // R9
   ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fault_o) |=> req_ready_o);

endmodule

bind cap_read_gate cap_read_gate_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid_i  (req_valid_i),
   .req_ready_o  (req_ready_o),
   .gc_clr_o     (gc_clr_o),
   .creg_we_o    (creg_we_o),
   .shadow_we_o  (shadow_we_o),
   .cap_gmark_o  (cap_gmark_o),
   .done_o       (done_o),
   .fault_o      (fault_o),
   .fault_code_o (fault_code_o)
);

// File: tb/cap_read_gate_tb_top.sv
`timescale 1ns/1ps
module cap_read_gate_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        req_valid_i = 1'b0;
   logic        req_ready_o;
   logic [2:0]  req_op_i = '0;
   logic        req_elev_i = 1'b0;
   logic [5:0]  req_perm_i = '0;
   logic [15:0] req_base_i = '0;
   logic [15:0] req_limit_i = '0;
   logic [7:0]  req_ver_i = '0;
   logic [31:0] req_seal_i = '0;
   logic        req_gmark_i = 1'b0;
   logic [15:0] req_off_i = '0;
   logic [7:0]  req_objver_i = '0;
   logic [7:0]  req_slot_i = '0;
   logic [3:0]  req_creg_i = '0;
   logic [2:0]  req_tid_i = '0;
   logic        gc_clr_o;
   logic [7:0]  gc_slot_o;
   logic        creg_we_o;
   logic [3:0]  creg_idx_o;
   logic        shadow_we_o;
   logic [2:0]  shadow_tid_o;
   logic [5:0]  cap_perm_o;
   logic [15:0] cap_base_o;
   logic [15:0] cap_limit_o;
   logic [7:0]  cap_ver_o;
   logic [31:0] cap_seal_o;
   logic        cap_gmark_o;
   logic        done_o;
   logic        fault_o;
   logic [2:0]  fault_code_o;

   cap_read_gate #(
      .ADDR_W (16), .OFF_W (16), .VER_W (8), .SLOT_W (8), .CR_W (4), .TID_W (3)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid_i (req_valid_i), .req_ready_o (req_ready_o),
      .req_op_i (req_op_i), .req_elev_i (req_elev_i), .req_perm_i (req_perm_i),
      .req_base_i (req_base_i), .req_limit_i (req_limit_i), .req_ver_i (req_ver_i),
      .req_seal_i (req_seal_i), .req_gmark_i (req_gmark_i), .req_off_i (req_off_i),
      .req_objver_i (req_objver_i), .req_slot_i (req_slot_i), .req_creg_i (req_creg_i),
      .req_tid_i (req_tid_i),
      .gc_clr_o (gc_clr_o), .gc_slot_o (gc_slot_o),
      .creg_we_o (creg_we_o), .creg_idx_o (creg_idx_o),
      .shadow_we_o (shadow_we_o), .shadow_tid_o (shadow_tid_o),
      .cap_perm_o (cap_perm_o), .cap_base_o (cap_base_o), .cap_limit_o (cap_limit_o),
      .cap_ver_o (cap_ver_o), .cap_seal_o (cap_seal_o), .cap_gmark_o (cap_gmark_o),
      .done_o (done_o), .fault_o (fault_o), .fault_code_o (fault_code_o)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic [5:0]  perm;
      logic [15:0] base;
      logic [15:0] limit;
      logic [15:0] off;
      logic [7:0]  ver;
      logic [7:0]  objver;
      logic        elev;
      logic        seal_ok;
      logic [2:0]  code;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{3'd0, 6'h01, 16'd100,    16'd200,    16'd50,     8'd3, 8'd3, 1'b0, 1'b1, 3'd0},
      '{3'd1, 6'h01, 16'd100,    16'd200,    16'd50,     8'd3, 8'd3, 1'b0, 1'b1, 3'd1},
      '{3'd5, 6'h20, 16'h0000,   16'hFFFF,   16'hFFFF,   8'd7, 8'd7, 1'b0, 1'b1, 3'd0},
      '{3'd3, 6'h08, 16'h8000,   16'hFFFF,   16'h8000,   8'd1, 8'd1, 1'b0, 1'b1, 3'd2},
      '{3'd2, 6'h04, 16'd10,     16'd20,     16'd11,     8'd1, 8'd1, 1'b0, 1'b1, 3'd2},
      '{3'd4, 6'h10, 16'd10,     16'd20,     16'd10,     8'd5, 8'd6, 1'b0, 1'b1, 3'd3},
      '{3'd6, 6'h3F, 16'd0,      16'd100,    16'd0,      8'd2, 8'd2, 1'b0, 1'b1, 3'd1},
      '{3'd7, 6'h00, 16'd1,      16'd2,      16'd1,      8'd9, 8'd9, 1'b1, 1'b1, 3'd0},
      '{3'd0, 6'h01, 16'd4,      16'd8,      16'd4,      8'd2, 8'd2, 1'b0, 1'b0, 3'd4},
      '{3'd1, 6'h00, 16'd100,    16'd50,     16'd0,      8'd1, 8'd1, 1'b1, 1'b1, 3'd2},
      '{3'd1, 6'h00, 16'd10,     16'd5,      16'd0,      8'd1, 8'd2, 1'b0, 1'b0, 3'd1},
      '{3'd3, 6'h08, 16'd0,      16'd10,     16'd1,      8'd4, 8'd5, 1'b0, 1'b0, 3'd3}
   };

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_seal(input logic [5:0] p, input logic [15:0] b,
                                            input logic [15:0] l, input logic [7:0] v);
      logic [7:0]  seq [6];
      logic [31:0] h;
      seq[0] = {2'b00, p};
      seq[1] = b[7:0];
      seq[2] = b[15:8];
      seq[3] = l[7:0];
      seq[4] = l[15:8];
      seq[5] = v;
      h = 32'h811C9DC5;
      for (int i = 0; i < 6; i++) h = (h ^ {24'd0, seq[i]}) * 32'h01000193;
      return h;
   endfunction

   int          gc_n, creg_n, sh_n, done_n, fault_n, ready_n, busy_ready;
   logic [2:0]  got_code;
   logic [7:0]  got_slot;
   logic [3:0]  got_creg;
   logic [2:0]  got_tid;
   logic [15:0] got_base;
   logic [31:0] got_seal;
   logic        got_gmark, pre_gmark;

   task automatic run_req(input vec_t v, input logic [31:0] seal, input logic [7:0] slot,
                          input logic [3:0] cr, input logic [2:0] tid, input bit stall);
      @(negedge clk);
      req_op_i = v.op;  req_perm_i = v.perm; req_base_i = v.base; req_limit_i = v.limit;
      req_off_i = v.off; req_ver_i = v.ver; req_objver_i = v.objver; req_elev_i = v.elev;
      req_seal_i = seal; req_gmark_i = 1'b1; req_slot_i = slot; req_creg_i = cr;
      req_tid_i = tid; req_valid_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid_i = 1'b0;
      gc_n = 0; creg_n = 0; sh_n = 0; done_n = 0; fault_n = 0; ready_n = 0; busy_ready = 0;
      got_code = '0; pre_gmark = cap_gmark_o;
      for (int n = 1; n <= 10; n++) begin
         @(posedge clk);
         @(negedge clk);
         if (gc_clr_o && gc_n == 0) begin gc_n = n; got_slot = gc_slot_o; end
         if (creg_we_o && creg_n == 0) begin
            creg_n = n; got_creg = creg_idx_o; got_base = cap_base_o;
            got_seal = cap_seal_o; got_gmark = cap_gmark_o;
         end
         if (shadow_we_o && sh_n == 0) begin sh_n = n; got_tid = shadow_tid_o; end
         if (done_o && done_n == 0) done_n = n;
         if (fault_o && fault_n == 0) begin fault_n = n; got_code = fault_code_o; end
         if (req_ready_o && ready_n == 0) begin
            ready_n = n;
            req_valid_i = 1'b0;
         end
         if (stall && n == 1) begin
            req_valid_i = 1'b1; req_op_i = 3'd6; req_base_i = 16'hDEAD;
         end
         if (req_ready_o && done_n == 0 && fault_n == 0) busy_ready = 1;
      end
      req_valid_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(req_ready_o == 1'b1, "R10", "ready", req_ready_o, 1);
      chk({gc_clr_o, creg_we_o, shadow_we_o, done_o, fault_o} == 5'd0, "R10", "strobes",
          {gc_clr_o, creg_we_o, shadow_we_o, done_o, fault_o}, 0);
      chk(fault_code_o == 3'd0, "R10", "fault_code", fault_code_o, 0);

      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         logic [31:0] s;
         string tag;
         v = VECS[i];
         s = ref_seal(v.perm, v.base, v.limit, v.ver);
         if (!v.seal_ok) s = s ^ 32'h0000_0100;
         run_req(v, s, 8'(8'h10 + i), 4'(i), 3'(i), 1'b0);
         case (v.code)
            3'd1: tag = "R2";
            3'd2: tag = "R3";
            3'd3: tag = "R4";
            3'd4: tag = "R5";
            default: tag = "R1";
         endcase
         if (v.code == 3'd0) begin
            chk(gc_n == 4, tag, $sformatf("vec%0d gc edge", i), gc_n, 4);
            chk(creg_n == 5, tag, $sformatf("vec%0d creg edge", i), creg_n, 5);
            chk(sh_n == 6, tag, $sformatf("vec%0d shadow edge", i), sh_n, 6);
            chk(done_n == 7, tag, $sformatf("vec%0d done edge", i), done_n, 7);
            chk(fault_n == 0, tag, $sformatf("vec%0d no fault", i), fault_n, 0);
            chk(got_slot == 8'(8'h10 + i) && got_creg == 4'(i) && got_tid == 3'(i), "R1",
                $sformatf("vec%0d slot/reg/tid", i), {got_slot, got_creg, got_tid},
                {8'(8'h10 + i), 4'(i), 3'(i)});
            // R8 mark bit before and after the collector step, payload intact
            chk(pre_gmark == 1'b1 && got_gmark == 1'b0, "R8", $sformatf("vec%0d gmark", i),
                {pre_gmark, got_gmark}, 2'b10);
            chk(got_base == v.base && got_seal == s, "R8", $sformatf("vec%0d payload", i),
                got_base, v.base);
            chk(ready_n == 8 && busy_ready == 0, "R9", $sformatf("vec%0d ready", i), ready_n, 8);
         end else begin
            chk(fault_n == int'(v.code) && got_code == v.code, tag,
                $sformatf("vec%0d fault edge/code", i), {fault_n[3:0], got_code},
                {4'(v.code), v.code});
            // R6 nothing of the success path after a fault
            chk(gc_n == 0 && creg_n == 0 && sh_n == 0 && done_n == 0, "R6",
                $sformatf("vec%0d no success strobes", i), {gc_n[3:0], creg_n[3:0]}, 0);
            chk(ready_n == int'(v.code) + 1 && busy_ready == 0, "R9",
                $sformatf("vec%0d ready", i), ready_n, v.code + 1);
         end
         if (v.elev) begin
            // R7 elevation passes permission only
            chk((v.code == 3'd0) ? (done_n == 7) : (got_code == v.code), "R7",
                $sformatf("vec%0d elevated", i), got_code, v.code);
         end
      end

      // R9 busy-time request held high is ignored
      begin
         vec_t v;
         logic [31:0] s;
         v = '{3'd3, 6'h08, 16'd40, 16'd90, 16'd20, 8'd6, 8'd6, 1'b0, 1'b1, 3'd0};
         s = ref_seal(v.perm, v.base, v.limit, v.ver);
         run_req(v, s, 8'hA5, 4'd9, 3'd5, 1'b1);
         chk(done_n == 7 && fault_n == 0, "R9", "stall done edge", done_n, 7);
         chk(got_base == 16'd40, "R9", "stall payload base", got_base, 40);
         chk(ready_n == 8 && busy_ready == 0, "R9", "stall ready", ready_n, 8);
         @(negedge clk);
         chk(req_ready_o == 1'b1 && fault_o == 1'b0, "R9", "idle after stall", req_ready_o, 1);
      end

      // R6 priority: every check would fail, permission reported
      begin
         vec_t v;
         v = '{3'd7, 6'h00, 16'hFFFF, 16'd0, 16'hFFFF, 8'd1, 8'd2, 1'b0, 1'b0, 3'd1};
         run_req(v, 32'd0, 8'd0, 4'd0, 3'd0, 1'b0);
         chk(fault_n == 1 && got_code == 3'd1, "R6", "priority code", got_code, 1);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule